// File: doc/BRIEF.md
# FM synthesizer interval timer and status unit

This block holds the two interval timers and the status byte of an FM sound generator. A host reaches it through a two-location byte port. A write to location 0 latches a register index. A write to location 1 stores the byte into the register that the index selects. A read of location 0 returns the status byte.

Each timer is an 8-bit counter that counts up from a preset. Software loads the preset with 256 minus the number of ticks it wants. When the counter wraps past 0xFF it reloads the preset and keeps running. The fast timer ticks every 80 µs. The slow timer ticks every 320 µs. An internal prescaler derives both tick rates from the system clock frequency parameter.

One control register holds a start bit and a mask bit for each timer, plus a flag-clear command. A wrap on an unmasked timer sets a sticky flag. The interrupt output follows the OR of the two flags.

Top module: `fm_timer_unit`

## Requirements
- R1: After reset, location 0 reads 0x06 and irq_o is low. Both timers are stopped and unmasked, and no flag rises without a start command.
- R2: A write to location 0 stores the register index. A write to location 1 stores data into the indexed register: 0x02 is the fast timer preset, 0x03 is the slow timer preset and 0x04 is control. Data writes to any other index change nothing.
- R3: A read of location 0 returns {irq, fast flag, slow flag, 5'b00110}, with irq in bit 7, the fast flag in bit 6 and the slow flag in bit 5. A read of location 1 returns 0x00.
- R4: The fast timer advances once every CLK_HZ·80 µs clock cycles. The slow timer advances on every fourth fast tick.
- R5: A running counter wraps after 256 minus preset ticks. It then reloads the preset and keeps counting, so it wraps again after the same number of ticks.
- R6: Control bit 0 starts the fast timer and bit 1 starts the slow timer. When a start bit goes from 0 to 1, the preset is loaded. When a start bit is cleared, the count freezes, and a later restart loads the preset again.
- R7: Control bit 6 masks the fast timer and bit 5 masks the slow timer. A wrap on a masked timer sets no flag.
- R8: A control write with bit 7 set clears both flags on the next cycle, and the other bits of that write are ignored. The clear also wins over a wrap in the same cycle.
- R9: irq_o equals status bit 7, which is the OR of the two flags.
- R10: A flag stays set until a clear command arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 1 | Port location: 0 is index and status, 1 is data |
| wr_i | input | 1 | Write strobe for one cycle |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Read byte for the location that addr_i selects |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The read data depends on addr_i and the registered flags through logic only. It is valid in the same cycle and carries no latency. A wrap raises its flag one clock after the tick edge on which the counter stood at 0xFF. A clear command empties the flags one clock after its data write. A start command loads the preset on the edge of its write, so the first tick after that edge counts from the preset. The bench steps a behavioural model on every rising edge with the same inputs as the design. It compares the status byte and the interrupt at each falling edge. Directed waits use margins that cover the unknown phase of the prescaler.

// File: rtl/fm_timer_pkg.sv
package fm_timer_pkg;
  localparam logic [7:0] IDX_PRE_FAST = 8'h02;
  localparam logic [7:0] IDX_PRE_SLOW = 8'h03;
  localparam logic [7:0] IDX_CTRL     = 8'h04;

  localparam int CTL_CLEAR = 7;
  localparam logic [4:0] ID_CODE = 5'b00110;

  localparam int NUM_TMR = 2;

  // timer 0 = fast, timer 1 = slow
  function automatic logic [7:0] preset_idx(input int t);
    return (t == 0) ? IDX_PRE_FAST : IDX_PRE_SLOW;
  endfunction

  function automatic int start_bit(input int t);
    return (t == 0) ? 0 : 1;
  endfunction

  function automatic int mask_bit(input int t);
    return (t == 0) ? 6 : 5;
  endfunction
endpackage

// File: rtl/fm_tick_gen.sv
module fm_tick_gen #(
  parameter longint unsigned CLK_HZ  = 50_000_000,
  parameter int              BASE_US = 80,
  parameter int              RATIO   = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic fast_o,
  output logic slow_o
);
  localparam longint unsigned FAST_DIV = (CLK_HZ / 1000) * BASE_US / 1000;
  localparam int DIV_W = (FAST_DIV > 1) ? $clog2(FAST_DIV) : 1;
  localparam int RAT_W = (RATIO > 1) ? $clog2(RATIO) : 1;

  logic [DIV_W-1:0] div_q;
  logic [RAT_W-1:0] sub_q;
  logic sub_wrap;

  assign fast_o   = (div_q == DIV_W'(FAST_DIV - 1));
  assign sub_wrap = (sub_q == RAT_W'(RATIO - 1));
  assign slow_o   = fast_o & sub_wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      sub_q <= '0;
    end else begin
      div_q <= fast_o ? '0 : div_q + 1'b1;
      if (fast_o) sub_q <= sub_wrap ? '0 : sub_q + 1'b1;
    end
  end
endmodule

// File: rtl/fm_preset_counter.sv
module fm_preset_counter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         run_i,
  input  logic         load_i,
  input  logic [W-1:0] preset_i,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q;
  logic at_top;

  assign at_top = &cnt_q;
  assign ovf_o  = tick_i & run_i & ~load_i & at_top;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= preset_i;
    else if (tick_i && run_i)  cnt_q <= at_top ? preset_i : cnt_q + 1'b1;
  end
endmodule

// File: rtl/fm_timer_unit.sv
module fm_timer_unit
  import fm_timer_pkg::*;
#(
  parameter longint unsigned CLK_HZ     = 50_000_000,
  parameter int              BASE_US    = 80,
  parameter int              SLOW_RATIO = 4,
  parameter int              DATA_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int ID_W = DATA_W - 3;

  logic [DATA_W-1:0]               idx_q;
  logic [NUM_TMR-1:0][DATA_W-1:0]  preset_q;
  logic [NUM_TMR-1:0]              start_q, mask_q, flag_q;
  logic [NUM_TMR-1:0]              new_start, new_mask, load, ovf, tick;
  logic fast_tick, slow_tick;
  logic data_wr, ctrl_wr, clr, cfg_wr;

  fm_tick_gen #(.CLK_HZ(CLK_HZ), .BASE_US(BASE_US), .RATIO(SLOW_RATIO)) i_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .fast_o(fast_tick),
    .slow_o(slow_tick)
  );

  assign data_wr = wr_i & addr_i;
  assign ctrl_wr = data_wr & (idx_q == DATA_W'(IDX_CTRL));
  assign clr     = ctrl_wr & wdata_i[CTL_CLEAR];
  assign cfg_wr  = ctrl_wr & ~wdata_i[CTL_CLEAR];

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    assign tick[t]      = (t == 0) ? fast_tick : slow_tick;
    assign new_start[t] = wdata_i[start_bit(t)];
    assign new_mask[t]  = wdata_i[mask_bit(t)];
    assign load[t]      = cfg_wr & new_start[t] & ~start_q[t];

    fm_preset_counter #(.W(DATA_W)) i_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick[t]),
      .run_i   (start_q[t]),
      .load_i  (load[t]),
      .preset_i(preset_q[t]),
      .ovf_o   (ovf[t])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q    <= '0;
      preset_q <= '0;
      start_q  <= '0;
      mask_q   <= '0;
      flag_q   <= '0;
    end else begin
      if (wr_i && !addr_i) idx_q <= wdata_i;
      for (int t = 0; t < NUM_TMR; t++) begin
        if (data_wr && idx_q == DATA_W'(preset_idx(t))) preset_q[t] <= wdata_i;
        // clear outranks a same-cycle wrap
        if (clr)                          flag_q[t] <= 1'b0;
        else if (ovf[t] && !mask_q[t])    flag_q[t] <= 1'b1;
      end
      if (cfg_wr) begin
        start_q <= new_start;
        mask_q  <= new_mask;
      end
    end
  end

  logic [DATA_W-1:0] status;
  assign irq_o   = |flag_q;
  assign status  = {irq_o, flag_q[0], flag_q[1], ID_W'(ID_CODE)};
  assign rdata_o = addr_i ? '0 : status;
endmodule

// File: rtl/fm_timer_chk.sv
module fm_timer_chk
  import fm_timer_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       addr_i,
  input logic       wr_i,
  input logic [7:0] wdata_i,
  input logic [7:0] idx_i,
  input logic [7:0] rdata_i,
  input logic       irq_i,
  input logic [1:0] flag_i,
  input logic [1:0] mask_i,
  input logic       fast_i,
  input logic       slow_i
);
  logic clr_cmd;
  assign clr_cmd = wr_i & addr_i & (idx_i == IDX_CTRL) & wdata_i[CTL_CLEAR];

  AST_IRQ_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_i |-> rdata_i[7] == irq_i); // R9
  AST_ID_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_i |-> rdata_i[4:0] == ID_CODE); // R3
  AST_DATA_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i |-> rdata_i == 8'h00); // R3
  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_cmd |=> flag_i == 2'b00); // R8
  AST_FLAG_STICKY0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_i[0] && !clr_cmd) |=> flag_i[0]); // R10
  AST_FLAG_STICKY1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_i[1] && !clr_cmd) |=> flag_i[1]); // R10
  AST_MASK_BLOCK0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_i[0]) |-> !$past(mask_i[0])); // R7
  AST_MASK_BLOCK1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_i[1]) |-> !$past(mask_i[1])); // R7
  AST_SLOW_IN_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slow_i |-> fast_i); // R4
  AST_SLOW_FLAG_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_i[1]) |-> $past(slow_i)); // R4
endmodule

bind fm_timer_unit fm_timer_chk i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .wr_i   (wr_i),
  .wdata_i(wdata_i),
  .idx_i  (idx_q),
  .rdata_i(rdata_o),
  .irq_i  (irq_o),
  .flag_i (flag_q),
  .mask_i (mask_q),
  .fast_i (fast_tick),
  .slow_i (slow_tick)
);

// File: tb/test_fm_timer_unit.sv
module test_fm_timer_unit;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_CYC   = 10;
  localparam longint unsigned CLK_HZ = TICK_CYC * 12500;

  logic clk = 0, rst_ni = 0, addr_i = 0, wr_i = 0;
  logic [7:0] wdata_i = 0, rdata_o;
  logic irq_o;
  int total = 0, bad = 0;
  bit finished = 0;

  fm_timer_unit #(.CLK_HZ(CLK_HZ)) i_fm_timer_unit (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  int m_div, m_sub, m_idx;
  int m_cnt[2], m_pre[2];
  bit m_run[2], m_msk[2], m_flg[2];

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_div = 0; m_sub = 0; m_idx = 0;
      for (int t = 0; t < 2; t++) begin
        m_cnt[t] = 0; m_pre[t] = 0; m_run[t] = 0; m_msk[t] = 0; m_flg[t] = 0;
      end
    end else begin
      bit tk[2], wrap[2], ld[2], clr_now, cfg_now;
      int n_idx, n_pre[2], n_cnt[2];
      bit n_run[2], n_msk[2], n_flg[2];
      tk[0] = (m_div == TICK_CYC - 1);
      tk[1] = tk[0] && (m_sub == 3);
      clr_now = wr_i && addr_i && m_idx == 4 && wdata_i[7];
      cfg_now = wr_i && addr_i && m_idx == 4 && !wdata_i[7];
      n_idx = (wr_i && !addr_i) ? int'(wdata_i) : m_idx;
      for (int t = 0; t < 2; t++) begin
        bit want_run;
        want_run = (t == 0) ? wdata_i[0] : wdata_i[1];
        ld[t] = cfg_now && want_run && !m_run[t];
        wrap[t] = tk[t] && m_run[t] && !ld[t] && m_cnt[t] == 255;
        n_pre[t] = (wr_i && addr_i && m_idx == 2 + t) ? int'(wdata_i) : m_pre[t];
        if (ld[t]) n_cnt[t] = m_pre[t];
        else if (tk[t] && m_run[t]) n_cnt[t] = wrap[t] ? m_pre[t] : m_cnt[t] + 1;
        else n_cnt[t] = m_cnt[t];
        n_run[t] = cfg_now ? want_run : m_run[t];
        n_msk[t] = cfg_now ? ((t == 0) ? wdata_i[6] : wdata_i[5]) : m_msk[t];
        n_flg[t] = clr_now ? 1'b0 : (m_flg[t] || (wrap[t] && !m_msk[t]));
      end
      if (tk[0]) m_sub = (m_sub + 1) % 4;
      m_div = tk[0] ? 0 : m_div + 1;
      m_idx = n_idx;
      for (int t = 0; t < 2; t++) begin
        m_pre[t] = n_pre[t]; m_cnt[t] = n_cnt[t]; m_run[t] = n_run[t];
        m_msk[t] = n_msk[t]; m_flg[t] = n_flg[t];
      end
    end
  end

  function automatic logic [7:0] exp_status();
    return {m_flg[0] | m_flg[1], m_flg[0], m_flg[1], 5'b00110};
  endfunction

  // every-cycle comparison (R3, R9)
  always @(negedge clk) begin
    if (rst_ni && !finished) begin
      logic [7:0] e;
      e = addr_i ? 8'h00 : exp_status();
      total++;
      if (rdata_o !== e) begin
        bad++;
        $display("FAIL R3 cycle compare rdata=%h expected=%h", rdata_o, e);
      end
      total++;
      if (irq_o !== (m_flg[0] | m_flg[1])) begin
        bad++;
        $display("FAIL R9 irq=%b expected=%b", irq_o, m_flg[0] | m_flg[1]);
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_reg(input logic [7:0] idx, input logic [7:0] val);
    addr_i = 0; wr_i = 1; wdata_i = idx; step(1);
    addr_i = 1; wr_i = 1; wdata_i = val; step(1);
    addr_i = 0; wr_i = 0; wdata_i = 0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    step(3);
    rst_ni = 1;
    step(1);
    chk("R1 reset status", rdata_o, 8'h06);
    chk("R1 reset irq", {7'd0, irq_o}, 8'h00);
    step(60);
    chk("R1 idle no flag", rdata_o, 8'h06);

    // R8: mask both, clear, then flags read 000
    wr_reg(8'h04, 8'h60);
    wr_reg(8'h04, 8'h80);
    chk("R8 cleared top bits", rdata_o & 8'hE0, 8'h00);

    // R5 R6: fast timer preset FF, start, slow masked
    wr_reg(8'h02, 8'hFF);
    wr_reg(8'h04, 8'h21);
    step(TICK_CYC + 2);
    chk("R5 fast wrap after one tick", rdata_o & 8'hE0, 8'hC0);
    chk("R9 irq after wrap", {7'd0, irq_o}, 8'h01);
    step(30);
    chk("R10 flag stays set", rdata_o & 8'hE0, 8'hC0);

    // R3 data location reads zero
    addr_i = 1; step(1);
    chk("R3 data location read", rdata_o, 8'h00);
    addr_i = 0;

    // R8: clear with start-slow bit set must not start slow timer
    wr_reg(8'h03, 8'hFF);
    wr_reg(8'h04, 8'h00);
    wr_reg(8'h04, 8'h82);
    chk("R8 clear took effect", rdata_o & 8'hE0, 8'h00);
    step(6 * TICK_CYC);
    chk("R8 extra bits ignored", rdata_o & 8'h20, 8'h00);

    // R2: writes to unused indices have no effect
    wr_reg(8'h07, 8'h03);
    wr_reg(8'h05, 8'h03);
    step(6 * TICK_CYC);
    chk("R2 unused index ignored", rdata_o, 8'h06);

    // R4 R7: slow preset FE (2 slow ticks), fast running but masked
    wr_reg(8'h03, 8'hFE);
    wr_reg(8'h04, 8'h43);
    step(4 * TICK_CYC - 5);
    chk("R4 slow not yet wrapped", rdata_o & 8'hE0, 8'h00);
    step(6 * TICK_CYC);
    chk("R4 slow wrapped", rdata_o & 8'h20, 8'h20);
    chk("R7 masked fast sets no flag", rdata_o & 8'h40, 8'h00);

    // R5: reload and wrap again after same count
    wr_reg(8'h04, 8'h00);
    wr_reg(8'h04, 8'h80);
    wr_reg(8'h02, 8'hFC);
    wr_reg(8'h04, 8'h21);
    step(4 * TICK_CYC + 2);
    chk("R5 first wrap", rdata_o & 8'h40, 8'h40);
    wr_reg(8'h04, 8'h80);
    step(2 * TICK_CYC);
    chk("R5 no early second wrap", rdata_o & 8'h40, 8'h00);
    step(3 * TICK_CYC);
    chk("R5 second wrap after reload", rdata_o & 8'h40, 8'h40);

    // R6: stop freezes, restart reloads preset
    wr_reg(8'h04, 8'h20);
    wr_reg(8'h04, 8'h80);
    wr_reg(8'h02, 8'hF0);
    wr_reg(8'h04, 8'h21);
    step(10 * TICK_CYC);
    wr_reg(8'h04, 8'h20);
    step(30 * TICK_CYC);
    chk("R6 stopped timer frozen", rdata_o & 8'h40, 8'h00);
    wr_reg(8'h04, 8'h21);
    step(12 * TICK_CYC);
    chk("R6 restart reloads preset", rdata_o & 8'h40, 8'h00);
    step(6 * TICK_CYC);
    chk("R6 wrap after full count", rdata_o & 8'h40, 8'h40);

    step(5);
    finish_run();
  end
endmodule